// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external interrupt pins into interrupt requests. Each pin has its own 2-bit sense mode, held in a control register on a small register bus. The four modes are a held low level, any change of level, a falling edge and a rising edge. The pins are brought into the clock domain through a synchronizer before any edge is judged. The pin is observed whatever its direction, so software that drives a pin configured as an output can raise its own interrupt through this block.

The edge-type modes latch an event into a sticky flag. The flag stays set until software writes a one to it, or until the interrupt controller pulses the acknowledge for that pin. Low-level mode keeps no flag. Its request follows the synchronized pin and drops as soon as the pin returns high. A pin's request reaches its output only when that pin's mask bit and the global enable are both set. Every request output is registered.

Top module: `ext_irq_sense`

## Requirements
- R1: The register bus has three addresses: 0 for the control register, 1 for the mask register and 2 for the flag register. Address 3 reads 0. The read data is registered, so it shows the register selected by `bus_addr` one cycle after that address is presented. The control register holds pin 0's mode in bits 1:0, pin 1's in bits 3:2 and pin 2's in bits 5:4. Its bits 7:6 ignore writes and read 0. All of its fields reset to 0.
- R2: The sense mode encodings are: 00 is a low level, 01 is any change, 10 is a falling edge and 11 is a rising edge.
- R3: Each pin passes through two synchronizer flops. A level change on a pin sets the flag at the third clock edge after the change and changes `irq_req` at the fourth. In low-level mode, the pin going low asserts `irq_req` at the third edge.
- R4: In the any-change, falling and rising modes, a matching transition between two consecutive synchronized samples sets the pin's flag (flag register bit n for pin n). A pulse that is held through one rising clock edge is caught.
- R5: In low-level mode, `irq_req[n]` is high for as long as the synchronized pin is low, and it drops when the pin goes high. This mode never sets a flag.
- R6: `irq_req[n]` is asserted only if `glob_en` and mask bit n were both high in the previous cycle.
- R7: A flag stays set until it is cleared by writing a 1 to its bit at address 2 or by a pulse on `irq_ack[n]`. If a new event falls in the same cycle as a clear, the flag stays set.
- R8: Writing a new sense mode never sets a flag by itself.
- R9: The mask register keeps pin masks in bits 2:0. Bits 7:3 read 0. The mask register resets to 0.
- R10: After reset, no event is detected and no low-level request is raised until the synchronizer and the previous-sample register have refilled, which takes three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for both write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| glob_en | input | 1 | Global interrupt enable |
| pin_in | input | 3 | External interrupt pins, asynchronous |
| irq_ack | input | 3 | Per-pin acknowledge, clears the flag |
| irq_req | output | 3 | Registered per-pin interrupt requests |

## Verification
A flag can be set by a newly detected edge in the same cycle that it is cleared, either by an acknowledge or by a write of a one to its bit. The bench drives a falling edge on a pin. It waits out the two synchronizer edges and pulses that pin's acknowledge in exactly the cycle in which the event is seen. It then reads the flag register and expects the bit still set. A later acknowledge with no event must clear it. The random phase lets writes, acknowledges and pin toggles collide freely. Each cycle it judges both the request outputs and the read data against a cycle-accurate model that the bench builds from the requirements.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin,
  input  logic   det_en,
  input  sense_e mode,
  output logic   level_low,
  output logic   event_hit
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   cur;
  logic                   raw_hit;

  // synchronizer chain, oldest sample in the top bit
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign cur = chain_q[SYNC_STAGES-1];

  always_comb begin
    case (mode)
      SNS_ANY:  raw_hit = cur ^ prev_q;
      SNS_FALL: raw_hit = prev_q & ~cur;
      SNS_RISE: raw_hit = ~prev_q & cur;
      default:  raw_hit = 1'b0;
    endcase
  end

  assign event_hit = det_en & raw_hit;
  assign level_low = det_en & ~cur;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] ack,
  input  logic [NUM_PINS-1:0] ev,
  output sense_e [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] flag_o
);

  localparam int unsigned CTRL_W = 2 * NUM_PINS;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] flag_clr;
  logic [DATA_W-1:0]   rd_d;
  logic                wr_ctrl, wr_mask, wr_flag;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_mask = bus_we && (bus_addr == ADDR_W'(ADDR_MASK));
  assign wr_flag = bus_we && (bus_addr == ADDR_W'(ADDR_FLAG));

  assign flag_clr = (wr_flag ? bus_wdata[NUM_PINS-1:0] : '0) | ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_mask) mask_q <= bus_wdata[NUM_PINS-1:0];
      // a fresh event outranks any clear in the same cycle
      flag_q <= (flag_q & ~flag_clr) | ev;
    end
  end

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      ADDR_W'(ADDR_CTRL): rd_d[CTRL_W-1:0]   = ctrl_q;
      ADDR_W'(ADDR_MASK): rd_d[NUM_PINS-1:0] = mask_q;
      ADDR_W'(ADDR_FLAG): rd_d[NUM_PINS-1:0] = flag_q;
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mode
    assign mode_o[g] = sense_e'(ctrl_q[2*g+1:2*g]);

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (flag_q[g] && !flag_clr[g]) |=> flag_q[g]); // R7

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      ev[g] |=> flag_q[g]); // R7

    AST_NO_SPONT_FLAG: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[g] && !ev[g]) |=> !flag_q[g]); // R8
  end

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:CTRL_W] == '0); // R1

  assign mask_o = mask_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                glob_en,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] irq_ack,
  output logic [NUM_PINS-1:0] irq_req
);

  localparam int unsigned PRIME_LIM = SYNC_STAGES + 1;
  localparam int unsigned PRIME_W   = $clog2(PRIME_LIM + 1);

  logic [PRIME_W-1:0]    prime_q;
  logic                  det_en;
  sense_e [NUM_PINS-1:0] mode_w;
  logic [NUM_PINS-1:0]   mask_w, flag_w, ev_w, lvl_w, req_d;

  // detection waits until the sample pipeline holds real pin values
  always_ff @(posedge clk) begin
    if (rst)                                prime_q <= '0;
    else if (prime_q != PRIME_W'(PRIME_LIM)) prime_q <= prime_q + 1'b1;
  end
  assign det_en = (prime_q == PRIME_W'(PRIME_LIM));

  irq_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ack       (irq_ack),
    .ev        (ev_w),
    .mode_o    (mode_w),
    .mask_o    (mask_w),
    .flag_o    (flag_w)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_sync_edge #(
      .SYNC_STAGES (SYNC_STAGES)
    ) u_det (
      .clk       (clk),
      .rst       (rst),
      .pin       (pin_in[g]),
      .det_en    (det_en),
      .mode      (mode_w[g]),
      .level_low (lvl_w[g]),
      .event_hit (ev_w[g])
    );

    assign req_d[g] = glob_en & mask_w[g] &
                      ((mode_w[g] == SNS_LOW) ? lvl_w[g] : flag_w[g]);

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
      !mask_w[g] |=> !irq_req[g]); // R6

    AST_LOW_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (mode_w[g] == SNS_LOW && !lvl_w[g]) |=> !irq_req[g]); // R5

    AST_LOW_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
      (mode_w[g] == SNS_LOW) |-> !ev_w[g]); // R5
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= req_d;
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (irq_req == '0)); // R6

  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (rst)
    !det_en |-> (ev_w == '0 && lvl_w == '0)); // R10

endmodule

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       glob_en = 1'b0;
  logic [2:0] pin_in = 3'b111;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_en(glob_en),
    .pin_in(pin_in), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // ---------------- reference model built from the requirements
  logic [2:0] m_s1, m_s2, m_prev, m_mask, m_flag, m_req;
  logic [5:0] m_ctrl;
  logic [7:0] m_rdata;
  int         m_prime;

  function automatic logic hit_fn(input logic [1:0] m, input logic c, input logic p);
    case (m)
      2'b01:   return c ^ p;
      2'b10:   return p & ~c;
      2'b11:   return ~p & c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] rd_fn(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_ctrl};
      2'd1:    return {5'b0, m_mask};
      2'd2:    return {5'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_prime <= 0;
      m_ctrl <= '0; m_mask <= '0; m_flag <= '0; m_req <= '0; m_rdata <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (m_prime < 3) m_prime <= m_prime + 1;
      if (bus_we && bus_addr == 2'd0) m_ctrl <= bus_wdata[5:0];
      if (bus_we && bus_addr == 2'd1) m_mask <= bus_wdata[2:0];
      for (int i = 0; i < 3; i++) begin
        logic clr, hit;
        clr = irq_ack[i] | (bus_we && bus_addr == 2'd2 && bus_wdata[i]);
        hit = (m_prime == 3) && hit_fn(m_ctrl[2*i+:2], m_s2[i], m_prev[i]);
        m_flag[i] <= (m_flag[i] & ~clr) | hit;
        m_req[i]  <= glob_en & m_mask[i] &
                     ((m_ctrl[2*i+:2] == 2'b00) ? ((m_prime == 3) & ~m_s2[i]) : m_flag[i]);
      end
      m_rdata <= rd_fn(bus_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3/R4/R5/R6 irq_req vs model", {29'b0, irq_req}, {29'b0, m_req});
      chk("R1 bus_rdata vs model", {24'b0, bus_rdata}, {24'b0, m_rdata});
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    tick();
    v = bus_rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'h5EED_0042);
    tick(4);
    rst = 1'b0;
    // R1 R9 reset state
    chk("R1 irq_req after reset", {29'b0, irq_req}, 0);
    rd(2'd0, v); chk("R1 control reset", {24'b0, v}, 0);
    rd(2'd1, v); chk("R9 mask reset", {24'b0, v}, 0);
    rd(2'd2, v); chk("R7 flags reset", {24'b0, v}, 0);
    tick(3);
    // R8 mode changes with steady high pins set no flag
    wr(2'd0, 8'h15); tick(2);
    wr(2'd0, 8'h2A); tick(2);
    wr(2'd0, 8'h3F); tick(4);
    rd(2'd2, v); chk("R8 no flag from mode change", {24'b0, v}, 0);
    // R1 reserved control bits
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R1 control reserved bits", {24'b0, v}, 8'h3F);
    rd(2'd3, v); chk("R1 unused address", {24'b0, v}, 0);
    // R9 mask width
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R9 mask reserved bits", {24'b0, v}, 8'h07);
    // R4 single-cycle falling pulse on pin 0, pins 0/1 falling, pin 2 low level
    wr(2'd0, 8'h0A);
    glob_en = 1'b1;
    pin_in[0] = 1'b0; tick();
    pin_in[0] = 1'b1; tick(3);
    chk("R4 short pulse request", {31'b0, irq_req[0]}, 1);
    rd(2'd2, v); chk("R4 short pulse flag", {24'b0, v}, 8'h01);
    glob_en = 1'b0; tick(2);
    chk("R6 global enable gates", {29'b0, irq_req}, 0);
    glob_en = 1'b1;
    // R7 write-one clear
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk("R7 write-one clear", {24'b0, v}, 0);
    // R7 event and acknowledge in the same cycle
    pin_in[1] = 1'b0; tick(2);
    irq_ack = 3'b010; tick();
    irq_ack = 3'b000;
    rd(2'd2, v); chk("R7 event beats same-cycle ack", {24'b0, v}, 8'h02);
    irq_ack = 3'b010; tick();
    irq_ack = 3'b000;
    rd(2'd2, v); chk("R7 ack clears flag", {24'b0, v}, 0);
    pin_in[1] = 1'b1; tick(4);
    wr(2'd2, 8'h07);
    // R3 R5 low level on pin 2
    pin_in[2] = 1'b0; tick(2);
    chk("R3 level not before third edge", {31'b0, irq_req[2]}, 0);
    tick();
    chk("R5 low level requests", {31'b0, irq_req[2]}, 1);
    tick(5);
    chk("R5 request held while low", {31'b0, irq_req[2]}, 1);
    pin_in[2] = 1'b1; tick(3);
    chk("R5 request drops when high", {31'b0, irq_req[2]}, 0);
    rd(2'd2, v); chk("R5 no flag in low mode", {24'b0, v}, 0);
    // R6 mask gating
    wr(2'd1, 8'h03);
    pin_in[2] = 1'b0; tick(5);
    chk("R6 mask blocks request", {31'b0, irq_req[2]}, 0);
    pin_in[2] = 1'b1; tick(4);
    // R10 reset again with a pin held low: nothing before refill
    rst = 1'b1; pin_in = 3'b010; tick(2);
    rst = 1'b0;
    wr(2'd1, 8'h07); glob_en = 1'b1;
    chk("R10 no request while refilling", {29'b0, irq_req}, 0);
    rd(2'd2, v); chk("R10 no flag while refilling", {24'b0, v}, 0);
    tick(4);
    pin_in = 3'b111; tick(4);
    // random phase, judged each cycle by the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(5) == 0) pin_in[$urandom_range(2)] ^= 1'b1;
      glob_en  = ($urandom_range(7) != 0);
      irq_ack  = ($urandom_range(5) == 0) ? 3'($urandom) : 3'b000;
      bus_addr = 2'($urandom);
      bus_we   = ($urandom_range(9) == 0);
      bus_wdata = 8'($urandom);
      tick();
    end
    bus_we = 1'b0; irq_ack = '0;
    tick(2);
    done = 1;
    summary();
    $finish;
  end

endmodule